// File: doc/BRIEF.md
# Keyed Flash Program/Erase Controller

This block sits between a simple register bus and a flash array. Software uses it to write one 32-bit word, to erase one 1 KB page, or to erase the whole array. The operand address and the data word go into two ordinary registers. A command register then starts the operation, but only when the upper half of the written word carries the fixed key 0xA442. While the operation runs, the command bit that started it stays set. It clears by itself when the array reports completion, so software can poll it to learn when the operation is over.

On the array side the block latches the operation address and the data word. It emits a single-cycle strobe for exactly one of three operations and waits for a one-cycle done pulse. A program-protect bank marks address regions as writable or locked. Word program and page erase aimed at a locked region never reach the array and raise an access-fault event. A read-protect bank and a microsecond reload register are kept for software. The two protect banks are write-zero-only. Completion and fault events land in a raw status register. A mask register selects which raw bits drive the interrupt line, and a masked status register reads raw AND mask. Writing 1 to a bit of the masked status register clears that raw bit.

Top module: `nvm_ctrl_top`

## Requirements
- R1: After reset the address, data, command, raw status, mask and masked status registers read 0. Both protect banks read 0xFFFF, the microsecond reload register reads 0x31, and irq is 0.
- R2: A write of 0xA4420001 to the command register (offset 0x08) makes fl_prog high for exactly the next cycle. In that cycle fl_addr is the address register with bits [1:0] cleared and fl_wdata is the data register. Command bit 0 reads 1 until completion.
- R3: A write of 0xA4420002 makes fl_perase high for exactly the next cycle, with fl_addr set to the address register with bits [9:0] cleared. Command bit 1 reads 1 until completion.
- R4: A write of 0xA4420004 makes fl_merase high for exactly the next cycle, whatever the address register and the program-protect bits hold. Command bit 2 reads 1 until completion.
- R5: A fl_done pulse while an operation runs clears the command register at the next edge and sets raw status bit 0.
- R6: A command write whose bits [31:16] differ from 0xA442 starts no operation and leaves the command register at 0.
- R7: A keyed command write with more than one of bits [2:0] set starts no operation and leaves the command register at 0.
- R8: A command write while an operation runs is ignored: no strobe is issued and the command register keeps its value.
- R9: Program-protect bit i covers address region i, which is address bits [ADDR_W-1:ADDR_W-4] with the default 16 bits. A program or page erase into a region whose bit is 0 issues no strobe, leaves the command register at 0 and sets raw status bit 1.
- R10: The read-protect bank (offset 0x30) and the program-protect bank (offset 0x34) only lose bits. A written 0 clears a bit, and a written 1 never sets it again.
- R11: The microsecond reload register (offset 0x40) can be read and written.
- R12: The mask register is at offset 0x10 and the masked status register at 0x14. The masked status reads raw AND mask, and irq is 1 exactly when that value is nonzero. Writing 1 to a bit at offset 0x14 clears that raw bit.
- R13: The raw status register (offset 0x0C) is read-only, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| fl_addr | output | ADDR_W | Latched operation byte address |
| fl_wdata | output | DATA_W | Latched program data |
| fl_prog | output | 1 | One-cycle word program strobe |
| fl_perase | output | 1 | One-cycle page erase strobe |
| fl_merase | output | 1 | One-cycle mass erase strobe |
| fl_done | input | 1 | One-cycle completion pulse from the array |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes near-miss keys and combined command bits. A design that checks only part of the key, or that picks one bit out of a combined word, would launch an operation here. It also writes a second command while the first is still pending. A controller that accepts this would re-strobe the array or overwrite the polled bit. Program and page erase are aimed at a locked region, and a mass erase is aimed at an address inside that region. A wrong region decode would either let a locked write through or wrongly block the mass erase. The bench writes ones into the cleared protect bits, writes to the raw status register, and clears a masked event. A design that let protection be restored, or confused raw and masked status, would show it on the read-back.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   localparam logic [15:0] CMD_KEY   = 16'hA442;
   localparam logic [7:0]  OFF_ADDR  = 8'h00;
   localparam logic [7:0]  OFF_DATA  = 8'h04;
   localparam logic [7:0]  OFF_CMD   = 8'h08;
   localparam logic [7:0]  OFF_RAW   = 8'h0C;
   localparam logic [7:0]  OFF_MASK  = 8'h10;
   localparam logic [7:0]  OFF_MSK   = 8'h14;
   localparam logic [7:0]  OFF_RDPR  = 8'h30;
   localparam logic [7:0]  OFF_PGPR  = 8'h34;
   localparam logic [7:0]  OFF_USEC  = 8'h40;
   localparam int          EVT_N     = 2;
   localparam int          EVT_DONE  = 0;
   localparam int          EVT_FAULT = 1;

   typedef struct packed {
      logic merase;
      logic perase;
      logic prog;
   } op_t;
endpackage

// File: rtl/nvm_prot_bank.sv
module nvm_prot_bank #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= 1'b1;
         else if (we && !wdata[i])
            q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
   import nvm_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 32,
   parameter int PROT_BITS  = 16,
   parameter int PAGE_BYTES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [15:0]       cmd_key,
   input  op_t               cmd_req,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] data_q,
   input  logic [PROT_BITS-1:0] pgprot,
   input  logic              fl_done,
   output op_t               cmd_bits,
   output op_t               strobe,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_wdata,
   output logic              evt_done,
   output logic              evt_fault
);
   localparam int REG_W  = $clog2(PROT_BITS);
   localparam int PAGE_W = $clog2(PAGE_BYTES);

   logic busy, key_ok, single, needs_prot, prot_ok, accept, launch;
   logic [REG_W-1:0]  region;
   logic [ADDR_W-1:0] launch_addr;

   assign busy       = |cmd_bits;
   assign key_ok     = (cmd_key == CMD_KEY);
   assign single     = $onehot(cmd_req);
   assign region     = addr_q[ADDR_W-1 -: REG_W];
   assign needs_prot = cmd_req.prog | cmd_req.perase;
   assign prot_ok    = pgprot[region];
   assign accept     = cmd_we && key_ok && !busy && single;
   assign evt_fault  = accept && needs_prot && !prot_ok;
   assign launch     = accept && !evt_fault;
   assign evt_done   = busy && fl_done;

   always_comb begin
      launch_addr = '0;
      if (cmd_req.perase)
         launch_addr = {addr_q[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
      else if (cmd_req.prog)
         launch_addr = {addr_q[ADDR_W-1:2], 2'b00};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_bits <= '0;
         strobe   <= '0;
         fl_addr  <= '0;
         fl_wdata <= '0;
      end else begin
         strobe <= launch ? cmd_req : '0;
         if (launch) begin
            cmd_bits <= cmd_req;
            fl_addr  <= launch_addr;
            fl_wdata <= data_q;
         end else if (evt_done) begin
            cmd_bits <= '0;
         end
      end
   end
endmodule

// File: rtl/nvm_irq.sv
module nvm_irq #(
   parameter int N       = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_we,
   input  logic [N-1:0] clr_data,
   input  logic         mask_we,
   input  logic [N-1:0] mask_wdata,
   output logic [N-1:0] raw,
   output logic [N-1:0] mask,
   output logic [N-1:0] masked,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            raw[i] <= 1'b0;
         else if (set[i])
            raw[i] <= 1'b1;
         else if (clr_we && clr_data[i])
            raw[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask <= '0;
      else if (mask_we)
         mask <= mask_wdata;
   end

   assign masked = raw & mask;

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            irq <= 1'b0;
         else
            irq <= |masked;
      end
   end else begin : g_irq_comb
      assign irq = |masked;
   end
endmodule

// File: rtl/nvm_ctrl_top.sv
module nvm_ctrl_top
   import nvm_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 32,
   parameter int PROT_BITS  = 16,
   parameter int PAGE_BYTES = 1024,
   parameter int USEC_W     = 8,
   parameter int USEC_RST   = 8'h31,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_wdata,
   output logic              fl_prog,
   output logic              fl_perase,
   output logic              fl_merase,
   input  logic              fl_done,
   output logic              irq
);
   if (ADDR_W > 32 || ADDR_W <= $clog2(PAGE_BYTES)) begin : g_bad_addr
      $error("nvm_ctrl_top: ADDR_W must exceed page bits and fit 32");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("nvm_ctrl_top: DATA_W must be 32");
   end
   if (PROT_BITS < 2 || PROT_BITS > 32 || (PROT_BITS & (PROT_BITS - 1)) != 0) begin : g_bad_prot
      $error("nvm_ctrl_top: PROT_BITS must be a power of two in 2..32");
   end
   if (USEC_W < 1 || USEC_W > 32) begin : g_bad_usec
      $error("nvm_ctrl_top: USEC_W out of range");
   end

   logic [ADDR_W-1:0]    addr_q;
   logic [DATA_W-1:0]    data_q;
   logic [USEC_W-1:0]    usec_q;
   logic [PROT_BITS-1:0] rdprot, pgprot;
   logic [EVT_N-1:0]     raw, mask, masked;
   op_t                  cmd_bits, strobe;
   logic                 evt_done, evt_fault;

   logic we_addr, we_data, we_cmd, we_mask, we_msk, we_rdpr, we_pgpr, we_usec;
   assign we_addr = bus_we && bus_addr == OFF_ADDR;
   assign we_data = bus_we && bus_addr == OFF_DATA;
   assign we_cmd  = bus_we && bus_addr == OFF_CMD;
   assign we_mask = bus_we && bus_addr == OFF_MASK;
   assign we_msk  = bus_we && bus_addr == OFF_MSK;
   assign we_rdpr = bus_we && bus_addr == OFF_RDPR;
   assign we_pgpr = bus_we && bus_addr == OFF_PGPR;
   assign we_usec = bus_we && bus_addr == OFF_USEC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         usec_q <= USEC_W'(USEC_RST);
      end else begin
         if (we_addr) addr_q <= bus_wdata[ADDR_W-1:0];
         if (we_data) data_q <= bus_wdata;
         if (we_usec) usec_q <= bus_wdata[USEC_W-1:0];
      end
   end

   nvm_prot_bank #(.W(PROT_BITS)) u_rdprot (
      .clk(clk), .rst_n(rst_n), .we(we_rdpr),
      .wdata(bus_wdata[PROT_BITS-1:0]), .q(rdprot)
   );

   nvm_prot_bank #(.W(PROT_BITS)) u_pgprot (
      .clk(clk), .rst_n(rst_n), .we(we_pgpr),
      .wdata(bus_wdata[PROT_BITS-1:0]), .q(pgprot)
   );

   nvm_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PROT_BITS(PROT_BITS), .PAGE_BYTES(PAGE_BYTES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(we_cmd), .cmd_key(bus_wdata[31:16]), .cmd_req(op_t'(bus_wdata[2:0])),
      .addr_q(addr_q), .data_q(data_q), .pgprot(pgprot),
      .fl_done(fl_done),
      .cmd_bits(cmd_bits), .strobe(strobe),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .evt_done(evt_done), .evt_fault(evt_fault)
   );

   assign fl_prog   = strobe.prog;
   assign fl_perase = strobe.perase;
   assign fl_merase = strobe.merase;

   logic [EVT_N-1:0] evt_set;
   always_comb begin
      evt_set            = '0;
      evt_set[EVT_DONE]  = evt_done;
      evt_set[EVT_FAULT] = evt_fault;
   end

   nvm_irq #(.N(EVT_N), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .set(evt_set),
      .clr_we(we_msk), .clr_data(bus_wdata[EVT_N-1:0]),
      .mask_we(we_mask), .mask_wdata(bus_wdata[EVT_N-1:0]),
      .raw(raw), .mask(mask), .masked(masked), .irq(irq)
   );

   always_comb begin
      case (bus_addr)
         OFF_ADDR: bus_rdata = 32'(addr_q);
         OFF_DATA: bus_rdata = 32'(data_q);
         OFF_CMD:  bus_rdata = 32'(cmd_bits);
         OFF_RAW:  bus_rdata = 32'(raw);
         OFF_MASK: bus_rdata = 32'(mask);
         OFF_MSK:  bus_rdata = 32'(masked);
         OFF_RDPR: bus_rdata = 32'(rdprot);
         OFF_PGPR: bus_rdata = 32'(pgprot);
         OFF_USEC: bus_rdata = 32'(usec_q);
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
   parameter int PROT_BITS = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_we,
   input logic [7:0]           bus_addr,
   input logic [31:0]          bus_wdata,
   input logic                 fl_prog,
   input logic                 fl_perase,
   input logic                 fl_merase,
   input logic                 fl_done,
   input logic                 irq,
   input logic [2:0]           cmd_bits,
   input logic [1:0]           raw,
   input logic [PROT_BITS-1:0] pgprot,
   input logic [PROT_BITS-1:0] rdprot
);
   logic cmd_wr;
   assign cmd_wr = bus_we && bus_addr == 8'h08;

   a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fl_prog, fl_perase, fl_merase}));

   a_r2_prog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fl_prog |=> !fl_prog);

   a_r3_perase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fl_perase |=> !fl_perase);

   a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_bits != 3'b000 && fl_done) |=> (cmd_bits == 3'b000 && raw[0]));

   a_r6_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata[31:16] != 16'hA442) |=> !(fl_prog || fl_perase || fl_merase));

   a_r7_multi_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && $countones(bus_wdata[2:0]) > 1) |=> !(fl_prog || fl_perase || fl_merase));

   a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_bits != 3'b000) |=> !(fl_prog || fl_perase || fl_merase));

   a_r9_fault_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw[1]) |-> !(fl_prog || fl_perase || fl_merase));

   a_r10_pgprot_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pgprot & ~$past(pgprot)) == '0));

   a_r10_rdprot_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((rdprot & ~$past(rdprot)) == '0));

   a_r12_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (raw != 2'b00));
endmodule

bind nvm_ctrl_top nvm_ctrl_chk #(.PROT_BITS(PROT_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .fl_prog(fl_prog), .fl_perase(fl_perase), .fl_merase(fl_merase),
   .fl_done(fl_done), .irq(irq),
   .cmd_bits(cmd_bits), .raw(raw), .pgprot(pgprot), .rdprot(rdprot)
);

// File: tb/sim_nvm_ctrl_top.sv
module sim_nvm_ctrl_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [16:0] fl_addr;
   logic [31:0] fl_wdata;
   logic        fl_prog, fl_perase, fl_merase;
   logic        fl_done = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   nvm_ctrl_top u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_prog(fl_prog), .fl_perase(fl_perase), .fl_merase(fl_merase),
      .fl_done(fl_done), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      fl_done = 1'b1;
      @(negedge clk);
      fl_done = 1'b0;
   endtask

   function automatic logic [31:0] strobes();
      return {29'd0, fl_merase, fl_perase, fl_prog};
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h00, v); check("R1 addr", v, 0);
      rd(8'h04, v); check("R1 data", v, 0);
      rd(8'h08, v); check("R1 cmd", v, 0);
      rd(8'h0C, v); check("R1 raw", v, 0);
      rd(8'h10, v); check("R1 mask", v, 0);
      rd(8'h14, v); check("R1 masked", v, 0);
      rd(8'h30, v); check("R1 rdprot", v, 32'hFFFF);
      rd(8'h34, v); check("R1 pgprot", v, 32'hFFFF);
      rd(8'h40, v); check("R1 usec", v, 32'h31);
      check("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_program();
      logic [31:0] v;
      wr(8'h04, 32'hDEADBEEF);
      wr(8'h00, 32'h0001234A);
      wr(8'h08, 32'hA4420001);
      check("R2 prog strobe", strobes(), 32'h1);
      check("R2 addr aligned", {15'd0, fl_addr}, 32'h12348);
      check("R2 wdata", fl_wdata, 32'hDEADBEEF);
      rd(8'h08, v); check("R2 cmd bit0 held", v, 32'h1);
      check("R2 strobe single cycle", strobes(), 0);
      done_pulse();
      rd(8'h08, v); check("R5 cmd self-clear", v, 0);
      rd(8'h0C, v); check("R5 raw done", v, 32'h1);
      wr(8'h14, 32'h3);
   endtask

   task automatic t_page_erase();
      logic [31:0] v;
      wr(8'h00, 32'h0000678A);
      wr(8'h08, 32'hA4420002);
      check("R3 perase strobe", strobes(), 32'h2);
      check("R3 page base", {15'd0, fl_addr}, 32'h6400);
      rd(8'h08, v); check("R3 cmd bit1 held", v, 32'h2);
      done_pulse();
      rd(8'h08, v); check("R3 R5 cmd cleared", v, 0);
      wr(8'h14, 32'h3);
   endtask

   task automatic t_bad_key();
      logic [31:0] v;
      wr(8'h08, 32'hA4430001);
      check("R6 no strobe", strobes(), 0);
      rd(8'h08, v); check("R6 cmd stays 0", v, 0);
      wr(8'h08, 32'h00000004);
      check("R6 no strobe zero key", strobes(), 0);
   endtask

   task automatic t_multi();
      logic [31:0] v;
      wr(8'h08, 32'hA4420003);
      check("R7 no strobe", strobes(), 0);
      rd(8'h08, v); check("R7 cmd stays 0", v, 0);
      wr(8'h08, 32'hA4420007);
      check("R7 no strobe three bits", strobes(), 0);
   endtask

   task automatic t_busy();
      logic [31:0] v;
      wr(8'h00, 32'h00000100);
      wr(8'h08, 32'hA4420001);
      check("R8 first strobe", strobes(), 32'h1);
      wr(8'h08, 32'hA4420002);
      check("R8 second ignored", strobes(), 0);
      rd(8'h08, v); check("R8 cmd unchanged", v, 32'h1);
      done_pulse();
      rd(8'h08, v); check("R8 cmd cleared", v, 0);
      wr(8'h14, 32'h3);
   endtask

   task automatic t_fault();
      logic [31:0] v;
      wr(8'h34, 32'h0000FFF7);
      wr(8'h00, 32'h00006000);
      wr(8'h08, 32'hA4420001);
      check("R9 no prog strobe", strobes(), 0);
      rd(8'h08, v); check("R9 cmd zero", v, 0);
      rd(8'h0C, v); check("R9 fault raw", v, 32'h2);
      wr(8'h14, 32'h2);
      wr(8'h00, 32'h00007FFC);
      wr(8'h08, 32'hA4420002);
      check("R9 no perase strobe", strobes(), 0);
      rd(8'h0C, v); check("R9 fault raw erase", v, 32'h2);
      wr(8'h14, 32'h3);
      wr(8'h00, 32'h00008000);
      wr(8'h08, 32'hA4420001);
      check("R9 open region allowed", strobes(), 32'h1);
      done_pulse();
      wr(8'h14, 32'h3);
   endtask

   task automatic t_mass();
      logic [31:0] v;
      wr(8'h00, 32'h00006004);
      wr(8'h08, 32'hA4420004);
      check("R4 merase strobe despite lock", strobes(), 32'h4);
      rd(8'h08, v); check("R4 cmd bit2 held", v, 32'h4);
      done_pulse();
      rd(8'h08, v); check("R4 R5 cmd cleared", v, 0);
      rd(8'h0C, v); check("R4 raw done", v, 32'h1);
      wr(8'h14, 32'h3);
   endtask

   task automatic t_prot();
      logic [31:0] v;
      rd(8'h34, v); check("R10 pgprot cleared bit", v, 32'hFFF7);
      wr(8'h34, 32'h0000FFFF);
      rd(8'h34, v); check("R10 pgprot no reset", v, 32'hFFF7);
      wr(8'h30, 32'h000000FF);
      rd(8'h30, v); check("R10 rdprot clear", v, 32'h00FF);
      wr(8'h30, 32'h0000FFFF);
      rd(8'h30, v); check("R10 rdprot no set", v, 32'h00FF);
   endtask

   task automatic t_usec();
      logic [31:0] v;
      wr(8'h40, 32'h000000A5);
      rd(8'h40, v); check("R11 usec write", v, 32'hA5);
      wr(8'h40, 32'h00000031);
      rd(8'h40, v); check("R11 usec restore", v, 32'h31);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(8'h08, 32'hA4420004);
      done_pulse();
      rd(8'h14, v); check("R12 masked zero", v, 0);
      check("R12 irq off unmasked", {31'd0, irq}, 0);
      wr(8'h10, 32'h1);
      rd(8'h14, v); check("R12 masked set", v, 32'h1);
      check("R12 irq on", {31'd0, irq}, 1);
      wr(8'h14, 32'h1);
      rd(8'h0C, v); check("R12 w1c raw", v, 0);
      check("R12 irq off after clear", {31'd0, irq}, 0);
   endtask

   task automatic t_raw_ro();
      logic [31:0] v;
      wr(8'h0C, 32'h3);
      rd(8'h0C, v); check("R13 raw read-only", v, 0);
      check("R13 irq unchanged", {31'd0, irq}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_page_erase();
      t_bad_key();
      t_multi();
      t_busy();
      t_fault();
      t_mass();
      t_prot();
      t_usec();
      t_irq();
      t_raw_ro();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule